// File: doc/BRIEF.md
# Thermal Alarm Logic With Consecutive-Sample Filter

This block turns a stream of signed temperature conversions into one alarm pin. Every accepted sample is sorted into one of three classes: hot (above the trip point), cold (below the hysteresis threshold) or in-band (neither). A filter then waits until the same class has been seen on a programmable number of consecutive conversions before it lets that class reach the alarm logic.

The alarm logic has two modes. As a thermostat comparator, the alarm turns on after a qualified hot result and turns off only after a qualified cold result. As an event interrupt, it latches on a qualified event and stays latched until software reads any register. The event it waits for alternates between hot and cold, so that each clear re-arms it for the opposite event.

The pad is open drain. Its output is a pull-low enable, and the polarity setting decides whether "active" means pulled low or released. A shutdown bit makes the block ignore all samples. Entering shutdown in interrupt mode drops a pending interrupt. The register file that holds trip, hysteresis and configuration is outside this block. Its power-up values are exported from the package:

- trip point 0x0A0, which is +80 °C;
- hysteresis threshold 0x096, which is +75 °C;
- configuration 0.

Top module: `tmon_alarm`

## Requirements
- R1: Samples, trip point and hysteresis threshold are 9-bit two's complement values at 0.5 °C per LSB (0x0FA = +125 °C, 0x192 = -55 °C). An accepted sample is hot when it is greater than the trip point, cold when it is less than the hysteresis threshold, and in-band otherwise. All comparisons are signed.
- R2: `cfg_i[4:3]` sets how many consecutive accepted samples of the same class are needed before that class acts: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6.
- R3: The consecutive count restarts at one whenever an accepted sample's class differs from the previous accepted sample's class. An in-band sample is a class of its own and therefore breaks a run.
- R4: In comparator mode (`cfg_i[1]`=0) the alarm becomes active on a qualified hot result and becomes inactive on a qualified cold result. Otherwise it holds its state.
- R5: In interrupt mode (`cfg_i[1]`=1) the block is armed for the hot event after reset. A qualified hot result latches the alarm active. The alarm then stays active regardless of later samples until a register read.
- R6: A register-read pulse (`reg_rd_i`) while an interrupt is latched clears it and switches the armed event. After the hot event is cleared, a qualified cold result latches the alarm again, and a read clears that too.
- R7: A register read while no interrupt is latched changes nothing, including which event is armed.
- R8: With `cfg_i[2]`=0 (active low) `pad_pull_lo_o` equals the active state. With `cfg_i[2]`=1 (active high) it is the inverse of the active state.
- R9: While `cfg_i[0]` (shutdown) is 1, samples are ignored. The comparator state and the filter count do not change.
- R10: When shutdown goes from 0 to 1 in interrupt mode, a latched interrupt is cleared on the next clock edge.
- R11: After reset the alarm is inactive, so with configuration 0 the pad is not pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_val_i | input | 9 | Signed temperature sample |
| smp_vld_i | input | 1 | Sample strobe, one cycle per conversion |
| trip_i | input | 9 | Signed trip point |
| hyst_i | input | 9 | Signed hysteresis threshold |
| cfg_i | input | 5 | {filter length[4:3], polarity[2], mode[1], shutdown[0]} |
| reg_rd_i | input | 1 | One-cycle pulse on any register read |
| pad_pull_lo_o | output | 1 | Open-drain pull-low enable for the alarm pin |

## Verification
The bench builds the block with its default parameters: a 9-bit sample and a 3-bit run counter. At that size all 512 sample codes can be swept upward and then downward, both with the power-up thresholds and with a pair of negative thresholds, so every signed boundary is exercised. The same build reaches all four filter lengths, including runs broken one sample short by an in-band value. It also steps the interrupt mode through the full arm/clear cycle, a stray read, and both polarities and shutdown entries.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int TEMP_W = 9;
    localparam int CNT_W  = 3;
    localparam int CFG_W  = 5;

    // Power-up values for the external register file
    localparam logic [TEMP_W-1:0] TRIP_RST = 9'h0A0;
    localparam logic [TEMP_W-1:0] HYST_RST = 9'h096;

    typedef enum logic [1:0] {
        SENSE_NONE = 2'd0,
        SENSE_MID  = 2'd1,
        SENSE_HOT  = 2'd2,
        SENSE_COLD = 2'd3
    } sense_e;

    // Filter length selected by the two-bit field
    function automatic int queue_len(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/tmon_fault_queue.sv
module tmon_fault_queue
    import tmon_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] smp_i,
    input  logic          vld_i,
    input  logic          shdn_i,
    input  logic [TW-1:0] trip_i,
    input  logic [TW-1:0] hyst_i,
    input  logic [1:0]    qsel_i,
    output logic          qual_hot_o,
    output logic          qual_cold_o
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        sense_e        sense;
        logic [CW-1:0] cnt;
    } fq_t;

    fq_t    st_d, st_q;
    sense_e sense_now;
    logic   take;
    int     need;

    always_comb begin
        take = vld_i && !shdn_i;
        need = queue_len(qsel_i);
        if ($signed(smp_i) > $signed(trip_i))      sense_now = SENSE_HOT;
        else if ($signed(smp_i) < $signed(hyst_i)) sense_now = SENSE_COLD;
        else                                       sense_now = SENSE_MID;

        st_d = st_q;
        if (take) begin
            st_d.sense = sense_now;
            if (sense_now != st_q.sense)  st_d.cnt = CNT_ONE;
            else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_ONE;
        end
        qual_hot_o  = take && (sense_now == SENSE_HOT)  && (int'(st_d.cnt) >= need);
        qual_cold_o = take && (sense_now == SENSE_COLD) && (int'(st_d.cnt) >= need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sense <= SENSE_NONE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a change of class restarts the run
    p_run_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sense_now != st_q.sense) |=> (st_q.cnt == CNT_ONE));

    // R9: nothing moves without an accepted sample
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q));

    // R1: a sample is never both hot and cold
    p_class_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({qual_hot_o, qual_cold_o}));
endmodule

// File: rtl/tmon_event.sv
module tmon_event (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_hot_i,
    input  logic qual_cold_i,
    input  logic rd_i,
    input  logic irq_mode_i,
    input  logic shdn_i,
    output logic active_o
);
    typedef struct packed {
        logic cmp;
        logic irq;
        logic arm_hi;
        logic shdn;
    } ev_t;

    ev_t  st_d, st_q;
    logic shdn_entry;
    logic armed_hit;

    always_comb begin
        shdn_entry = irq_mode_i && shdn_i && !st_q.shdn;
        armed_hit  = st_q.arm_hi ? qual_hot_i : qual_cold_i;

        st_d      = st_q;
        st_d.shdn = shdn_i;

        if (qual_hot_i)       st_d.cmp = 1'b1;
        else if (qual_cold_i) st_d.cmp = 1'b0;

        if (st_q.irq) begin
            if (rd_i) begin
                st_d.irq    = 1'b0;
                st_d.arm_hi = !st_q.arm_hi;
            end
        end else if (irq_mode_i && armed_hit) begin
            st_d.irq = 1'b1;
        end

        if (shdn_entry) st_d.irq = 1'b0;

        active_o = irq_mode_i ? st_q.irq : st_q.cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp    <= 1'b0;
            st_q.irq    <= 1'b0;
            st_q.arm_hi <= 1'b1;
            st_q.shdn   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: latched interrupt survives anything but a read or shutdown entry
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !rd_i && !shdn_entry) |=> st_q.irq);

    // R6: a read clears a latched interrupt and flips the armed event
    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && rd_i) |=> (!st_q.irq && (st_q.arm_hi != $past(st_q.arm_hi))));

    // R7: without a latched interrupt the armed event never changes
    p_arm_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq |=> $stable(st_q.arm_hi));

    // R10: entering shutdown in interrupt mode drops the interrupt
    p_shdn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_entry |=> !st_q.irq);

    // R9: thermostat state frozen during shutdown
    p_cmp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_i |=> $stable(st_q.cmp));
endmodule

// File: rtl/tmon_alarm.sv
module tmon_alarm
    import tmon_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] smp_val_i,
    input  logic          smp_vld_i,
    input  logic [TW-1:0] trip_i,
    input  logic [TW-1:0] hyst_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic          reg_rd_i,
    output logic          pad_pull_lo_o
);
    logic shdn, irq_mode, pol_hi;
    logic [1:0] qsel;
    logic qual_hot, qual_cold, active;

    assign shdn     = cfg_i[0];
    assign irq_mode = cfg_i[1];
    assign pol_hi   = cfg_i[2];
    assign qsel     = cfg_i[4:3];

    tmon_fault_queue #(.TW(TW), .CW(CW)) u_fq (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp_val_i),
        .vld_i       (smp_vld_i),
        .shdn_i      (shdn),
        .trip_i      (trip_i),
        .hyst_i      (hyst_i),
        .qsel_i      (qsel),
        .qual_hot_o  (qual_hot),
        .qual_cold_o (qual_cold)
    );

    tmon_event u_ev (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual_hot_i  (qual_hot),
        .qual_cold_i (qual_cold),
        .rd_i        (reg_rd_i),
        .irq_mode_i  (irq_mode),
        .shdn_i      (shdn),
        .active_o    (active)
    );

    // Active-high setting releases the pin when the alarm is active
    assign pad_pull_lo_o = pol_hi ? !active : active;
endmodule

// File: tb/tb_tmon_alarm.sv
module tb_tmon_alarm;
    import tmon_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] smp = '0;
    logic       vld = 1'b0;
    logic [8:0] trip = TRIP_RST;
    logic [8:0] hyst = HYST_RST;
    logic [4:0] cfg = '0;
    logic       rd = 1'b0;
    logic       pad;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmon_alarm dut (
        .clk(clk), .rst_n(rst_n), .smp_val_i(smp), .smp_vld_i(vld),
        .trip_i(trip), .hyst_i(hyst), .cfg_i(cfg), .reg_rd_i(rd),
        .pad_pull_lo_o(pad)
    );

    localparam logic [8:0] HOT  = 9'd170;
    localparam logic [8:0] MID  = 9'd155;
    localparam logic [8:0] COLD = 9'd100;

    task automatic chk(input string tag, input logic exp_active);
        logic exp_pad;
        exp_pad = cfg[2] ? !exp_active : exp_active;
        n_run++;
        if (pad !== exp_pad) begin
            n_fail++;
            $display("FAIL %s: pad=%b expected %b", tag, pad, exp_pad);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b0; rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [8:0] v);
        smp = v; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic send_n(input logic [8:0] v, input int n);
        for (int k = 0; k < n; k++) send(v);
    endtask

    task automatic pulse_rd();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic sweep(input int tr, input int hy);
        logic e;
        e = 1'b0;
        do_reset();
        cfg = 5'b00000;
        trip = 9'(tr); hyst = 9'(hy);
        send(9'(hy - 10));
        for (int i = -256; i < 256; i++) begin
            send(9'(i));
            if (i > tr) e = 1'b1; else if (i < hy) e = 1'b0;
            chk("R1 R4 up-sweep", e);
        end
        for (int i = 255; i >= -256; i--) begin
            send(9'(i));
            if (i > tr) e = 1'b1; else if (i < hy) e = 1'b0;
            chk("R1 R4 down-sweep", e);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        do_reset();
        chk("R11 reset inactive", 1'b0);

        // R1 R4: signed sweeps with default and negative thresholds
        sweep(int'($signed(TRIP_RST)), int'($signed(HYST_RST)));
        sweep(-20, -30);

        // R2 R3: every filter length
        for (int q = 0; q < 4; q++) begin
            int n;
            n = queue_len(2'(q));
            do_reset();
            trip = TRIP_RST; hyst = HYST_RST;
            cfg = {2'(q), 3'b000};
            send_n(COLD, n);
            send_n(HOT, n - 1);
            chk("R2 one short of run", 1'b0);
            send(HOT);
            chk("R2 full run asserts", 1'b1);
            send_n(COLD, n - 1);
            send(MID);
            send_n(COLD, n - 1);
            chk("R3 mid sample breaks run", 1'b1);
            send(COLD);
            chk("R3 restarted run completes", 1'b0);
        end

        // R5 R6 R7: interrupt cycle
        do_reset();
        trip = TRIP_RST; hyst = HYST_RST;
        cfg = 5'b00010;
        send(COLD);
        chk("R5 cold ignored while armed high", 1'b0);
        send(HOT);
        chk("R5 hot latches", 1'b1);
        send_n(COLD, 3);
        chk("R5 held across cold samples", 1'b1);
        pulse_rd();
        chk("R6 read clears high event", 1'b0);
        send_n(HOT, 2);
        chk("R6 hot ignored once armed low", 1'b0);
        send(COLD);
        chk("R6 cold event latches", 1'b1);
        pulse_rd();
        chk("R6 read clears low event", 1'b0);
        pulse_rd();
        chk("R7 idle read no change", 1'b0);
        send(HOT);
        chk("R7 still armed high after idle read", 1'b1);

        // R8: polarity in both states
        cfg = 5'b00110;
        @(negedge clk);
        chk("R8 active high releases when active", 1'b1);
        pulse_rd();
        chk("R8 active high pulls when inactive", 1'b0);

        // R9: comparator state frozen in shutdown
        do_reset();
        cfg = 5'b00000;
        send(HOT);
        chk("R9 comparator active before shutdown", 1'b1);
        cfg = 5'b00001;
        send_n(COLD, 3);
        chk("R9 cold ignored in shutdown", 1'b1);
        cfg = 5'b01000;
        send(COLD);
        chk("R9 count not advanced in shutdown", 1'b1);
        send(COLD);
        chk("R9 resumes after shutdown", 1'b0);

        // R10: shutdown entry drops interrupt
        do_reset();
        cfg = 5'b00010;
        send(HOT);
        chk("R10 interrupt latched", 1'b1);
        cfg = 5'b00011;
        @(negedge clk);
        chk("R10 shutdown entry clears", 1'b0);
        send_n(HOT, 2);
        chk("R10 samples ignored in shutdown", 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule